// File: doc/BRIEF.md
# Programmable Even-Ratio Clock Prescaler

This block divides a reference clock by an even, software-chosen ratio. It holds one
8-bit control value `n` and produces an output clock at the reference frequency
divided by 2(n+1). The high phase and the low phase each last n+1 reference cycles,
so the duty cycle is always 50%. The all-ones code is reserved: it stops the divider
and sends the reference clock straight to the output. The block comes out of reset in
this pass-through mode.

The control value sits behind a small parallel bus with an address, a write strobe,
write data and combinational read data. The output drives a frequency multiplier, so
the output must stay regular. A new divisor takes effect only at the next output
toggle. Changes into or out of pass-through happen only while both the reference
clock and the divided clock are low. The design assumes that the reference is at least
about 1 MHz and that the output frequency suits the multiplier downstream. The
hardware does not enforce these limits.

Top module: `clk_prescaler`

## Requirements
- R1: A synchronous active-high reset sets the control value to 0xFF, clears the divider counter, holds the divided clock low and leaves the block in pass-through mode.
- R2: For a control value n from 0 to 254, every high phase and every low phase of `clk_out` lasts exactly n+1 rising edges of `clk`, which gives a ratio of 2(n+1) at 50% duty.
- R3: With control value 0xFF, `clk_out` equals `clk`: high after each rising edge and low after each falling edge.
- R4: A write with `wr_en` high and `addr` equal to `REG_ADDR` stores `wr_data` at the next rising edge of `clk`. `rd_data` shows the stored value while `addr` equals `REG_ADDR` and shows zero for any other address.
- R5: A write to any other address leaves the control value unchanged.
- R6: A divisor written during a running phase does not alter the length of that phase. The new value governs the phases that follow the next toggle of the divided clock.
- R7: The output source changes only while `clk` and the divided clock are both low. The first high phase after pass-through ends has the full length n+1. The divided clock finishes its current high phase before pass-through begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data, the control value when addressed, otherwise zero |
| clk_out | output | 1 | Prescaled clock, or the reference clock in pass-through |

## Verification
The bench builds the block with its default parameters: an 8-bit control value, a 4-bit address and the control register at address 0xE. At this width the largest divisor, 254, has half-periods of 255 cycles, so the bench can measure the extreme ratio in a few thousand cycles alongside the smallest ratios. The bench times the phases at the falling edge, where pass-through always reads low. This lets it see directly whether a phase was shortened while the output enters or leaves pass-through.

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int W        = 8,
  parameter int ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'hE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  output logic              clk_out
);
  localparam logic [W-1:0] BYPASS = '1;

  logic [W-1:0] ctl_q;
  logic [W-1:0] n_hold;
  logic [W-1:0] cnt_q;
  logic         div_q;
  logic         byp_act;

  wire hit      = (addr == REG_ADDR);
  wire boundary = (cnt_q == n_hold);

  always_ff @(posedge clk) begin
    if (rst)               ctl_q <= BYPASS;
    else if (wr_en && hit) ctl_q <= wr_data;
  end

  assign rd_data = hit ? ctl_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_hold <= BYPASS;
      cnt_q  <= '0;
      div_q  <= 1'b0;
    end else if (byp_act) begin
      n_hold <= ctl_q;
      cnt_q  <= '0;
      div_q  <= 1'b0;
    end else if (boundary) begin
      n_hold <= ctl_q;
      cnt_q  <= '0;
      div_q  <= (ctl_q == BYPASS) ? 1'b0 : ~div_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(negedge clk) begin
    if (rst)         byp_act <= 1'b1;
    else if (!div_q) byp_act <= (n_hold == BYPASS);
  end

  assign clk_out = (clk & byp_act) | (div_q & ~byp_act);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (ctl_q == BYPASS && cnt_q == '0 && !div_q))
    else $error("reset state wrong");

  assert_bypass_div_low_R3: assert property (@(posedge clk) disable iff (rst)
    byp_act |-> !div_q)
    else $error("divider active during pass-through");

  assert_write_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit) |=> (ctl_q == $past(wr_data)))
    else $error("write not stored");

  assert_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |=> (ctl_q == $past(ctl_q)))
    else $error("foreign write changed control value");

  assert_switch_low_R7: assert property (@(posedge clk) disable iff (rst)
    (byp_act != $past(byp_act)) |-> !div_q)
    else $error("source switched while divided clock high");
endmodule

// File: tb/clk_prescaler_tb.sv
module clk_prescaler_tb_top;
  localparam logic [3:0] RA = 4'hE;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = RA;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       clk_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  clk_prescaler dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = RA;
  endtask

  task automatic sample(output logic v);
    @(negedge clk); #1 v = clk_out;
  endtask

  task automatic wait_rise(output bit ok);
    logic v, p;
    ok = 1'b0;
    sample(p);
    for (int i = 0; i < 3000; i++) begin
      sample(v);
      if (p == 1'b0 && v == 1'b1) begin ok = 1'b1; break; end
      p = v;
    end
  endtask

  task automatic run_len(input logic lvl, input int start, output int len);
    logic v;
    len = start;
    for (int i = 0; i < 3000; i++) begin
      sample(v);
      if (v != lvl) break;
      len++;
    end
  endtask

  task automatic check_bypass(input string req);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 check(clk_out == 1'b1, req, clk_out, 1);
      @(negedge clk); #1 check(clk_out == 1'b0, req, clk_out, 0);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check(rd_data == 8'hFF, "R1", rd_data, 8'hFF);
    check_bypass("R1");
    check_bypass("R3");
  endtask

  task automatic t_bus;
    bus_write(RA, 8'h5A);
    #1 check(rd_data == 8'h5A, "R4", rd_data, 8'h5A);
    addr = 4'h3; #1 check(rd_data == 8'h00, "R4", rd_data, 0);
    addr = RA;
    bus_write(4'h3, 8'h11);
    #1 check(rd_data == 8'h5A, "R5", rd_data, 8'h5A);
    bus_write(4'hF, 8'hC3);
    #1 check(rd_data == 8'h5A, "R5", rd_data, 8'h5A);
  endtask

  task automatic t_ratio(input logic [7:0] n);
    bit ok; int h, l;
    bus_write(RA, n);
    wait_rise(ok);
    run_len(1'b1, 1, h);
    run_len(1'b0, 1, l);
    run_len(1'b1, 1, h);
    run_len(1'b0, 1, l);
    check(ok, "R2", ok, 1);
    check(h == n + 1, "R2", h, n + 1);
    check(l == n + 1, "R2", l, n + 1);
  endtask

  task automatic t_midchange;
    bit ok; int h, l, h2;
    bus_write(RA, 8'd5);
    wait_rise(ok);
    wait_rise(ok);
    bus_write(RA, 8'd1);
    run_len(1'b1, 3, h);
    run_len(1'b0, 1, l);
    run_len(1'b1, 1, h2);
    check(h == 6, "R6", h, 6);
    check(l == 2, "R6", l, 2);
    check(h2 == 2, "R6", h2, 2);
  endtask

  task automatic t_bypass_edges;
    bit ok; int h, z;
    logic v;
    bus_write(RA, 8'hFF);
    repeat (12) @(posedge clk);
    check_bypass("R3");
    bus_write(RA, 8'd3);
    wait_rise(ok);
    run_len(1'b1, 1, h);
    check(h == 4, "R7", h, 4);
    wait_rise(ok);
    bus_write(RA, 8'hFF);
    run_len(1'b1, 3, h);
    check(h == 4, "R7", h, 4);
    z = 0;
    for (int i = 0; i < 20; i++) begin
      sample(v);
      if (v == 1'b0) z++;
    end
    check(z == 20, "R7", z, 20);
    check_bypass("R7");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bus();
    t_ratio(8'd0);
    t_ratio(8'd1);
    t_ratio(8'd2);
    t_ratio(8'd5);
    t_ratio(8'd254);
    t_midchange();
    t_bypass_edges();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule